// File: doc/BRIEF.md
# Instruction Prefetch Window Buffer

This block keeps a small window of consecutive instruction bytes copied from linear memory and answers instruction fetches of one to four bytes out of it. A fetch that lies wholly inside a valid window is answered on the next cycle with no memory traffic. A fetch that misses loads a fresh window as a burst of word reads from a simple request/acknowledge read port, then answers from the new window. When a full window would run past the segment limit, the fetch becomes a single direct read. When paging is enabled, a window that would cross a 4096-byte page is pulled back to end on the page boundary. If the pulled-back window cannot hold the whole fetch, the window is invalidated and the fetch becomes a direct read.

Stores seen on a snoop port patch any window bytes they touch, so the window never goes stale behind a write. A context-switch strobe drops the window. A failed fill invalidates the window and returns an error with the response. The requester issues a fetch only while `req_ready` is high and holds the fetch fields for that one cycle. It then waits for the single-cycle `rsp_valid` pulse. Byte order is little-endian, so the byte at the fetch address lands in `rsp_data[7:0]`.

Top module: `pfw_prefetch_window`

## Requirements
- R1: After reset `rsp_valid` and `mem_rd_req` are low, `req_ready` is high, and the window is invalid, so the first fetch always goes to memory.
- R2: A fetch that misses, lies within the limit and can be covered loads the window with WIN_BYTES/4 consecutive 4-byte reads, starting at the window start and stepping by 4. It then gives exactly one response carrying the requested bytes. `mem_rd_req` and `mem_rd_addr` stay steady until acknowledged.
- R3: A fetch whose bytes all lie in a valid window (address minus window base, plus size, at most WIN_BYTES) is answered on the next cycle without any memory read.
- R4: When `req_off` + WIN_BYTES − 1 exceeds `req_limit`, the fetch is served by one direct read at `req_addr`, and the window's valid state is left as it was.
- R5: With `paging_en` high and `req_addr[11:0]` greater than 4096 − WIN_BYTES, the window starts at the page base plus 4096 − WIN_BYTES.
- R6: If, after that clamp, (address − window start + size) ≥ WIN_BYTES, the window is invalidated and the fetch is served by one direct read.
- R7: A fill read acknowledged with `mem_rd_err` ends the burst at once. The response carries `rsp_err`=1, and the window is invalid afterwards.
- R8: A snooped write (`wr_size` 1..4 bytes, little-endian in `wr_data`) overwrites every byte of a valid window whose address it covers. Bytes outside the window are unaffected.
- R9: `flush` invalidates the window. A flush during a fill still returns the data but leaves the window invalid.
- R10: `req_size` encodes the byte count 1..4 in binary. Response bytes at and above that count are zero.
- R11: With `paging_en` low, no clamp applies, and a window may span a page boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Fetch request strobe |
| req_ready | output | 1 | Block idle; a fetch may be issued |
| req_addr | input | 32 | Linear address of the first fetch byte |
| req_off | input | 32 | Offset of the fetch within its segment |
| req_limit | input | 32 | Segment limit (last valid offset) |
| req_size | input | 3 | Fetch byte count, 1..4 |
| paging_en | input | 1 | Paging enabled; activates the page clamp |
| wr_valid | input | 1 | Snooped write strobe |
| wr_addr | input | 32 | Linear address of the first written byte |
| wr_size | input | 3 | Written byte count, 1..4 |
| wr_data | input | 32 | Written bytes, little-endian |
| flush | input | 1 | Context-switch strobe; drops the window |
| mem_rd_req | output | 1 | Memory read request, held until acknowledged |
| mem_rd_addr | output | 32 | Byte address of the 4-byte read |
| mem_rd_ack | input | 1 | Read acknowledge, one cycle |
| mem_rd_err | input | 1 | Read failed; valid with acknowledge |
| mem_rd_data | input | 32 | Four bytes from `mem_rd_addr` upward, little-endian |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_data | output | 32 | Fetched bytes, upper bytes zero |
| rsp_err | output | 1 | Fill or direct read failed |

## Verification
The bench targets the window edges. It issues fetches that end exactly on the last window byte and fetches that overrun it by one. A design with an off-by-one hit test would either read memory needlessly or return wrapped bytes. It places fetches on the clamp threshold and just above it, including the case where the request ends exactly on the window end. A design that used `>` instead of `≥` there would fill instead of reading directly, and a wrong clamp shows up as a wrong first read address. Other cases cover a fill that faults on its third word, where a design that finished the burst or left the window valid would show four reads or a later false hit. Snooped writes straddle the window's lower and upper ends, and a flush lands in the middle of a fill; a design that revalidated there would answer the next fetch without reading memory.

// File: rtl/pfw_pkg.sv
package pfw_pkg;

  localparam int unsigned PAGE_BYTES = 4096;
  localparam int unsigned PAGE_BITS  = 12;

  typedef enum logic [1:0] {
    PL_HIT    = 2'd0,
    PL_FILL   = 2'd1,
    PL_DIRECT = 2'd2
  } plan_t;

  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_FILL   = 2'd1,
    SQ_DIRECT = 2'd2
  } seq_st_t;

  typedef enum logic {
    TP_IDLE = 1'b0,
    TP_WAIT = 1'b1
  } top_st_t;

  // Keep the lowest n bytes of a word, zero the rest.
  function automatic logic [31:0] keep_low(input logic [31:0] w, input logic [2:0] n);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < n) r[8*k +: 8] = w[8*k +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/pfw_plan.sv
module pfw_plan
  import pfw_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16
) (
  input  logic [31:0] addr,
  input  logic [31:0] off,
  input  logic [31:0] limit,
  input  logic [2:0]  size,
  input  logic        paging_en,
  input  logic        win_valid,
  input  logic [31:0] win_base,
  output plan_t       kind,
  output logic [31:0] fill_start,
  output logic        drop_valid
);

  localparam logic [32:0] WIN33     = 33'(WIN_BYTES);
  localparam logic [11:0] CLAMP_OFS = 12'(PAGE_BYTES - WIN_BYTES);

  logic [32:0] reach;
  logic        in_limit;
  logic        clamp;
  logic [31:0] start_c;
  logic [32:0] span;
  logic        covers;
  logic [31:0] hdiff;
  logic        hit;

  always_comb begin
    reach    = {1'b0, off} + WIN33 - 33'd1;
    in_limit = reach <= {1'b0, limit};

    clamp   = paging_en && (addr[PAGE_BITS-1:0] > CLAMP_OFS);
    start_c = clamp ? {addr[31:PAGE_BITS], CLAMP_OFS} : addr;
    span    = {1'b0, addr - start_c} + 33'(size);
    covers  = span < WIN33;

    hdiff = addr - win_base;
    hit   = win_valid && (addr >= win_base) && (({1'b0, hdiff} + 33'(size)) <= WIN33);

    drop_valid = 1'b0;
    if (!in_limit) begin
      kind = PL_DIRECT;
    end else if (hit) begin
      kind = PL_HIT;
    end else if (!covers) begin
      kind       = PL_DIRECT;
      drop_valid = 1'b1;
    end else begin
      kind = PL_FILL;
    end
    fill_start = start_c;
  end

endmodule

// File: rtl/pfw_window.sv
module pfw_window #(
  parameter int unsigned WIN_BYTES = 16,
  localparam int unsigned OFFW     = $clog2(WIN_BYTES),
  localparam int unsigned IDXW     = $clog2(WIN_BYTES / 4)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fill_we,
  input  logic [IDXW-1:0] fill_idx,
  input  logic [31:0]     fill_word,
  input  logic            wr_valid,
  input  logic [31:0]     wr_addr,
  input  logic [2:0]      wr_size,
  input  logic [31:0]     wr_data,
  input  logic            win_valid,
  input  logic [31:0]     win_base,
  input  logic [OFFW-1:0] rd_off,
  input  logic [2:0]      rd_size,
  output logic [31:0]     rd_data
);

  logic [7:0]           bytes [WIN_BYTES];
  logic [WIN_BYTES-1:0][3:0] snp;

  // Which snooped lane, if any, lands on each window byte.
  always_comb begin
    for (int i = 0; i < WIN_BYTES; i++) begin
      for (int j = 0; j < 4; j++) begin
        snp[i][j] = wr_valid && win_valid && (3'(j) < wr_size) &&
                    ((wr_addr + 32'(j) - win_base) == 32'(i));
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < WIN_BYTES; i++) begin
      if (fill_we && (fill_idx == IDXW'(i / 4))) begin
        bytes[i] <= fill_word[8*(i%4) +: 8];
      end else begin
        for (int j = 0; j < 4; j++) begin
          if (snp[i][j]) bytes[i] <= wr_data[8*j +: 8];
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int k = 0; k < 4; k++) begin
      if (3'(k) < rd_size) rd_data[8*k +: 8] = bytes[OFFW'(rd_off + OFFW'(k))];
    end
  end

  AST_FILL_SNOOP_EXCL: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> (snp == '0)); // R8

endmodule

// File: rtl/pfw_seq.sv
module pfw_seq
  import pfw_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16,
  localparam int unsigned NWORDS   = WIN_BYTES / 4,
  localparam int unsigned IDXW     = $clog2(NWORDS)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            go_fill,
  input  logic            go_direct,
  input  logic [31:0]     start_addr,
  output logic            mem_rd_req,
  output logic [31:0]     mem_rd_addr,
  input  logic            mem_rd_ack,
  input  logic            mem_rd_err,
  input  logic [31:0]     mem_rd_data,
  output logic            fill_we,
  output logic [IDXW-1:0] fill_idx,
  output logic [31:0]     fill_word,
  output logic            fill_ok,
  output logic            fill_fail,
  output logic            dir_done,
  output logic            dir_err,
  output logic [31:0]     dir_word
);

  seq_st_t st;

  assign fill_we   = (st == SQ_FILL) && mem_rd_ack && !mem_rd_err;
  assign fill_word = mem_rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= SQ_IDLE;
      mem_rd_req  <= 1'b0;
      mem_rd_addr <= '0;
      fill_idx    <= '0;
      fill_ok     <= 1'b0;
      fill_fail   <= 1'b0;
      dir_done    <= 1'b0;
      dir_err     <= 1'b0;
      dir_word    <= '0;
    end else begin
      fill_ok   <= 1'b0;
      fill_fail <= 1'b0;
      dir_done  <= 1'b0;
      unique case (st)
        SQ_IDLE: begin
          if (go_fill) begin
            st          <= SQ_FILL;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= start_addr;
            fill_idx    <= '0;
          end else if (go_direct) begin
            st          <= SQ_DIRECT;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= start_addr;
          end
        end
        SQ_FILL: begin
          if (mem_rd_ack) begin
            if (mem_rd_err) begin
              st         <= SQ_IDLE;
              mem_rd_req <= 1'b0;
              fill_fail  <= 1'b1;
            end else if (fill_idx == IDXW'(NWORDS - 1)) begin
              st         <= SQ_IDLE;
              mem_rd_req <= 1'b0;
              fill_ok    <= 1'b1;
            end else begin
              fill_idx    <= fill_idx + 1'b1;
              mem_rd_addr <= mem_rd_addr + 32'd4;
            end
          end
        end
        SQ_DIRECT: begin
          if (mem_rd_ack) begin
            st         <= SQ_IDLE;
            mem_rd_req <= 1'b0;
            dir_done   <= 1'b1;
            dir_err    <= mem_rd_err;
            dir_word   <= mem_rd_data;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_addr))); // R2

  AST_SINGLE_END: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fill_ok, fill_fail, dir_done})); // R2

endmodule

// File: rtl/pfw_prefetch_window.sv
module pfw_prefetch_window
  import pfw_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 16,
  localparam int unsigned OFFW     = $clog2(WIN_BYTES),
  localparam int unsigned IDXW     = $clog2(WIN_BYTES / 4)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_off,
  input  logic [31:0] req_limit,
  input  logic [2:0]  req_size,
  input  logic        paging_en,
  input  logic        wr_valid,
  input  logic [31:0] wr_addr,
  input  logic [2:0]  wr_size,
  input  logic [31:0] wr_data,
  input  logic        flush,
  output logic        mem_rd_req,
  output logic [31:0] mem_rd_addr,
  input  logic        mem_rd_ack,
  input  logic        mem_rd_err,
  input  logic [31:0] mem_rd_data,
  output logic        rsp_valid,
  output logic [31:0] rsp_data,
  output logic        rsp_err
);

  top_st_t         tst;
  logic            win_valid;
  logic [31:0]     win_base;
  logic [OFFW-1:0] held_off;
  logic [2:0]      held_size;
  logic            flush_seen;

  plan_t           kind;
  logic [31:0]     fill_start;
  logic            drop_valid;
  logic            accept;
  logic            go_fill;
  logic            go_direct;

  logic            fill_we;
  logic [IDXW-1:0] fill_idx;
  logic [31:0]     fill_word;
  logic            fill_ok;
  logic            fill_fail;
  logic            dir_done;
  logic            dir_err;
  logic [31:0]     dir_word;

  logic [OFFW-1:0] rd_off;
  logic [2:0]      rd_size;
  logic [31:0]     win_rd;
  logic [31:0]     hit_diff;

  assign req_ready = (tst == TP_IDLE);
  assign accept    = req_valid && req_ready;
  assign go_fill   = accept && (kind == PL_FILL);
  assign go_direct = accept && (kind == PL_DIRECT);
  assign hit_diff  = req_addr - win_base;
  assign rd_off    = (tst == TP_IDLE) ? hit_diff[OFFW-1:0] : held_off;
  assign rd_size   = (tst == TP_IDLE) ? req_size : held_size;

  pfw_plan #(.WIN_BYTES(WIN_BYTES)) u_plan (
    .addr       (req_addr),
    .off        (req_off),
    .limit      (req_limit),
    .size       (req_size),
    .paging_en  (paging_en),
    .win_valid  (win_valid),
    .win_base   (win_base),
    .kind       (kind),
    .fill_start (fill_start),
    .drop_valid (drop_valid)
  );

  pfw_seq #(.WIN_BYTES(WIN_BYTES)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .go_fill     (go_fill),
    .go_direct   (go_direct),
    .start_addr  (go_fill ? fill_start : req_addr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_addr (mem_rd_addr),
    .mem_rd_ack  (mem_rd_ack),
    .mem_rd_err  (mem_rd_err),
    .mem_rd_data (mem_rd_data),
    .fill_we     (fill_we),
    .fill_idx    (fill_idx),
    .fill_word   (fill_word),
    .fill_ok     (fill_ok),
    .fill_fail   (fill_fail),
    .dir_done    (dir_done),
    .dir_err     (dir_err),
    .dir_word    (dir_word)
  );

  pfw_window #(.WIN_BYTES(WIN_BYTES)) u_win (
    .clk       (clk),
    .rst       (rst),
    .fill_we   (fill_we),
    .fill_idx  (fill_idx),
    .fill_word (fill_word),
    .wr_valid  (wr_valid),
    .wr_addr   (wr_addr),
    .wr_size   (wr_size),
    .wr_data   (wr_data),
    .win_valid (win_valid),
    .win_base  (win_base),
    .rd_off    (rd_off),
    .rd_size   (rd_size),
    .rd_data   (win_rd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tst        <= TP_IDLE;
      win_valid  <= 1'b0;
      win_base   <= '0;
      held_off   <= '0;
      held_size  <= '0;
      flush_seen <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      unique case (tst)
        TP_IDLE: begin
          if (accept) begin
            held_size <= req_size;
            unique case (kind)
              PL_HIT: begin
                rsp_valid <= 1'b1;
                rsp_data  <= win_rd;
              end
              PL_FILL: begin
                win_base   <= fill_start;
                held_off   <= OFFW'(req_addr - fill_start);
                win_valid  <= 1'b0;
                flush_seen <= 1'b0;
                tst        <= TP_WAIT;
              end
              default: begin
                if (drop_valid) win_valid <= 1'b0;
                tst <= TP_WAIT;
              end
            endcase
          end
        end
        TP_WAIT: begin
          if (fill_ok) begin
            rsp_valid <= 1'b1;
            rsp_data  <= win_rd;
            win_valid <= !flush_seen;
            tst       <= TP_IDLE;
          end else if (fill_fail) begin
            rsp_valid <= 1'b1;
            rsp_err   <= 1'b1;
            rsp_data  <= '0;
            win_valid <= 1'b0;
            tst       <= TP_IDLE;
          end else if (dir_done) begin
            rsp_valid <= 1'b1;
            rsp_err   <= dir_err;
            rsp_data  <= dir_err ? 32'd0 : keep_low(dir_word, held_size);
            tst       <= TP_IDLE;
          end
        end
        default: tst <= TP_IDLE;
      endcase
      if (flush) begin
        win_valid <= 1'b0;
        if (tst == TP_WAIT) flush_seen <= 1'b1;
      end
    end
  end

  AST_HIT_NO_MEM: assert property (@(posedge clk) disable iff (rst)
    (accept && kind == PL_HIT) |=> !mem_rd_req); // R3

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (rst)
    flush |=> !win_valid); // R9

  AST_FAIL_REPORTS: assert property (@(posedge clk) disable iff (rst)
    fill_fail |=> (rsp_valid && rsp_err && !win_valid)); // R7

  AST_CLAMP_PAGE: assert property (@(posedge clk) disable iff (rst)
    (go_fill && paging_en) |-> ((fill_start[31:PAGE_BITS] == req_addr[31:PAGE_BITS]) &&
                                (fill_start[PAGE_BITS-1:0] <= 12'(PAGE_BYTES - WIN_BYTES)))); // R5

  AST_LIMIT_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (accept && ({1'b0, req_off} + 33'(WIN_BYTES) - 33'd1 > {1'b0, req_limit}))
      |=> (mem_rd_req && mem_rd_addr == $past(req_addr))); // R4

endmodule

// File: tb/pfw_prefetch_window_tb.sv
module pfw_prefetch_window_tb;

  localparam int WIN = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [31:0] req_off = '0;
  logic [31:0] req_limit = '0;
  logic [2:0]  req_size = 3'd1;
  logic        paging_en = 1'b0;
  logic        wr_valid = 1'b0;
  logic [31:0] wr_addr = '0;
  logic [2:0]  wr_size = 3'd1;
  logic [31:0] wr_data = '0;
  logic        flush = 1'b0;
  logic        mem_rd_req;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_ack;
  logic        mem_rd_err;
  logic [31:0] mem_rd_data;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic        rsp_err;

  int total = 0;
  int bad   = 0;
  int reads = 0;
  int mark  = 0;
  logic [31:0] first_addr;

  always #5 clk = ~clk;

  pfw_prefetch_window #(.WIN_BYTES(WIN)) u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_off(req_off), .req_limit(req_limit), .req_size(req_size),
    .paging_en(paging_en),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .flush(flush),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_ack(mem_rd_ack),
    .mem_rd_err(mem_rd_err), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err)
  );

  function automatic logic [7:0] mb(input logic [31:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  function automatic logic [31:0] expect_bytes(input logic [31:0] a, input int n);
    logic [31:0] r;
    r = '0;
    for (int k = 0; k < n; k++) r[8*k +: 8] = mb(a + 32'(k));
    return r;
  endfunction

  // Memory model: word reads in [0x9000,0x9010) fail.
  always @(posedge clk) begin
    if (rst) begin
      mem_rd_ack  <= 1'b0;
      mem_rd_err  <= 1'b0;
      mem_rd_data <= '0;
    end else if (mem_rd_req && !mem_rd_ack) begin
      mem_rd_ack  <= 1'b1;
      mem_rd_err  <= (mem_rd_addr >= 32'h9000) && (mem_rd_addr < 32'h9010);
      mem_rd_data <= expect_bytes(mem_rd_addr, 4);
      if (reads == mark) first_addr <= mem_rd_addr;
      reads <= reads + 1;
    end else begin
      mem_rd_ack <= 1'b0;
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  logic [31:0] g_data;
  logic        g_err;
  int          g_reads;

  task automatic fetch(input logic [31:0] a, input logic [31:0] o, input logic [31:0] lim,
                       input logic pg, input logic [2:0] sz, input int flush_at);
    int cyc;
    @(negedge clk);
    mark      = reads;
    req_addr  = a;
    req_off   = o;
    req_limit = lim;
    paging_en = pg;
    req_size  = sz;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!rsp_valid && cyc < 1000) begin
      if (cyc == flush_at) flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      cyc++;
    end
    if (cyc >= 1000) begin
      total++;
      bad++;
      $display("FAIL R2 response timeout got=none exp=rsp_valid");
    end
    g_data  = rsp_data;
    g_err   = rsp_err;
    g_reads = reads - mark;
  endtask

  task automatic snoop(input logic [31:0] a, input logic [2:0] sz, input logic [31:0] d);
    @(negedge clk);
    wr_addr  = a;
    wr_size  = sz;
    wr_data  = d;
    wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  typedef struct packed {
    logic [31:0] addr;
    logic [31:0] off;
    logic        pg;
    logic [2:0]  sz;
    logic [3:0]  nrd;
    logic [31:0] first;
    logic        err;
    logic [3:0]  tag;
  } vec_t;

  localparam vec_t TBL [15] = '{
    '{32'h1000, 32'h0100, 1'b0, 3'd4, 4'd4, 32'h1000, 1'b0, 4'd1},  // R1 R2 first fill
    '{32'h1004, 32'h0104, 1'b0, 3'd2, 4'd0, 32'h0,    1'b0, 4'd3},  // R3 hit
    '{32'h100C, 32'h010C, 1'b0, 3'd4, 4'd0, 32'h0,    1'b0, 4'd3},  // R3 ends on last byte
    '{32'h100D, 32'h010D, 1'b0, 3'd4, 4'd4, 32'h100D, 1'b0, 4'd2},  // R2 overrun by one
    '{32'h2000, 32'hFFF5, 1'b0, 3'd4, 4'd1, 32'h2000, 1'b0, 4'd4},  // R4 over limit
    '{32'h100E, 32'h010E, 1'b0, 3'd1, 4'd0, 32'h0,    1'b0, 4'd4},  // R4 window kept, R10
    '{32'h3FF5, 32'h0200, 1'b1, 3'd4, 4'd4, 32'h3FF0, 1'b0, 4'd5},  // R5 clamp
    '{32'h3FF0, 32'h0200, 1'b1, 3'd1, 4'd0, 32'h0,    1'b0, 4'd5},  // R5 clamped base hit
    '{32'h4FFE, 32'h0200, 1'b1, 3'd2, 4'd1, 32'h4FFE, 1'b0, 4'd6},  // R6 cannot cover
    '{32'h3FF0, 32'h0200, 1'b1, 3'd1, 4'd4, 32'h3FF0, 1'b0, 4'd6},  // R6 window dropped
    '{32'h5FF8, 32'h0300, 1'b0, 3'd4, 4'd4, 32'h5FF8, 1'b0, 4'd11}, // R11 no clamp
    '{32'h6004, 32'h030C, 1'b0, 3'd4, 4'd0, 32'h0,    1'b0, 4'd11}, // R11 across page
    '{32'h8FF8, 32'h0400, 1'b0, 3'd4, 4'd3, 32'h8FF8, 1'b1, 4'd7},  // R7 fault on word 3
    '{32'h6004, 32'h030C, 1'b0, 3'd4, 4'd4, 32'h6004, 1'b0, 4'd7},  // R7 window dropped
    '{32'h6005, 32'h030D, 1'b0, 3'd3, 4'd0, 32'h0,    1'b0, 4'd10}  // R10 three bytes
  };

  initial begin
    #2000000;
    total++;
    bad++;
    $display("FAIL watchdog got=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    check("R1 mem_rd_req", {31'd0, mem_rd_req}, 32'd0);
    check("R1 req_ready", {31'd0, req_ready}, 32'd1);

    foreach (TBL[i]) begin
      vec_t v;
      string tg;
      v = TBL[i];
      tg = $sformatf("R%0d row%0d", v.tag, i);
      fetch(v.addr, v.off, 32'hFFFF, v.pg, v.sz, -1);
      check({tg, " reads"}, 32'(g_reads), 32'(v.nrd));
      check({tg, " err"}, {31'd0, g_err}, {31'd0, v.err});
      if (!v.err) check({tg, " data"}, g_data, expect_bytes(v.addr, int'(v.sz)));
      if (v.nrd != 0) check({tg, " first"}, first_addr, v.first);
    end

    // R8 snooped writes
    fetch(32'h1000, 32'h100, 32'hFFFF, 1'b0, 3'd4, -1);
    snoop(32'h1002, 3'd2, 32'h0000BEEF);
    fetch(32'h1000, 32'h100, 32'hFFFF, 1'b0, 3'd4, -1);
    check("R8 inner write", g_data, {8'hBE, 8'hEF, mb(32'h1001), mb(32'h1000)});
    check("R8 inner reads", 32'(g_reads), 32'd0);
    snoop(32'h100E, 3'd4, 32'h44332211);
    fetch(32'h100C, 32'h10C, 32'hFFFF, 1'b0, 3'd4, -1);
    check("R8 upper straddle", g_data, {8'h22, 8'h11, mb(32'h100D), mb(32'h100C)});
    snoop(32'h0FFE, 3'd4, 32'hDDCCBBAA);
    fetch(32'h1000, 32'h100, 32'hFFFF, 1'b0, 3'd2, -1);
    check("R8 lower straddle", g_data, 32'h0000DDCC);
    snoop(32'h2000, 3'd4, 32'hFFFFFFFF);
    fetch(32'h1004, 32'h104, 32'hFFFF, 1'b0, 3'd4, -1);
    check("R8 outside write", g_data, expect_bytes(32'h1004, 4));

    // R9 flush
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    fetch(32'h1000, 32'h100, 32'hFFFF, 1'b0, 3'd4, -1);
    check("R9 flush refill reads", 32'(g_reads), 32'd4);
    fetch(32'h7000, 32'h500, 32'hFFFF, 1'b0, 3'd4, 2);
    check("R9 flush mid-fill data", g_data, expect_bytes(32'h7000, 4));
    fetch(32'h7000, 32'h500, 32'hFFFF, 1'b0, 3'd1, -1);
    check("R9 flush mid-fill invalid", 32'(g_reads), 32'd4);
    fetch(32'h7001, 32'h501, 32'hFFFF, 1'b0, 3'd1, -1);
    check("R9 clean fill valid", 32'(g_reads), 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule